// File: doc/BRIEF.md
# Asynchronous Serial Channel with Multiprocessor Flag Bit

This block is one full-duplex asynchronous serial channel. Bytes to send enter through a valid/ready stream, wait in a single-entry buffer and leave on `txd` as framed characters. Characters arriving on `rxd` are checked and passed out through a second valid/ready stream. An optional multiprocessor format adds a flag bit after the eight data bits. On the transmit side a control input gives the value of that bit. On the receive side the flag lands in a status output that only the block itself updates.

Bit timing comes from the channel's own baud generator. A prescaler divides the system clock by 1, 4, 16 or 64. An 8-bit divisor N then divides the prescaled clock again by N+1, which gives an oversampling tick at sixteen times the bit rate. The divisor register can be written and read back at any time. Reset and the standby input both return it to all ones. Standby also stops both framing engines at once and holds the line high.

Stream rules: a transmit byte is accepted on a clock edge where `tx_valid` and `tx_ready` are both high. `tx_ready` stays low until the transmitter has taken the byte. On the receive side, `rx_valid` holds together with `rx_data` and `rx_mpb` until an edge where `rx_ready` is high. A character that completes while the holding register is still occupied, including the edge on which it is released, is discarded whole, flag bit included.

Top module: `mpser_chan`

## Requirements
- R1: After reset `div_rd` reads 8'hFF. A write through `div_we`/`div_wdata` appears on `div_rd` one clock later. After reset `tx_ready`=1, `rx_valid`=0, `txd`=1, `rx_ferr`=0 and `rx_mpb`=0.
- R2: While `standby` is high, `div_rd` returns to 8'hFF on the next edge, both engines abandon any character in progress, and `txd` is high from the next edge on.
- R3: One bit lasts 16*(N+1)*P system clocks. N is the divisor value. P is 1, 4, 16 or 64 for `clk_sel` values 0, 1, 2 or 3.
- R4: A transmitted character is a low start bit, then 8 data bits least significant first, then the flag bit when `mp_en`=1, then a high stop bit lasting at least one bit period. Each bit starts on an oversampling tick.
- R5: With `mp_en`=1, the value of `tx_mpb` when the character starts becomes its flag bit. With `mp_en`=0 no flag bit is sent and `tx_mpb` has no effect, so the stop bit follows data bit 7 directly.
- R6: `tx_ready` is high exactly while the transmit buffer is empty. A buffered byte is kept until `tx_en`=1, `sync_mode`=0 and `standby`=0, and is then sent unchanged.
- R7: A received character with a valid (high) stop bit sets `rx_valid` and presents its byte on `rx_data`. When the character was received in the flag format, its flag bit goes to `rx_mpb` in the same edge.
- R8: The receiver checks the start bit at its middle. If the line is high again by then, the event is dropped and nothing is reported.
- R9: A low stop bit sets `rx_ferr` and commits neither the byte nor the flag bit. The next character with a valid stop bit clears `rx_ferr`.
- R10: While `rx_valid`=1 and `rx_ready`=0, `rx_valid`, `rx_data` and `rx_mpb` hold. A character that completes while the holding register is occupied is discarded.
- R11: `rx_mpb` keeps its previous value while `rx_en`=0, in which case nothing is received, and also across characters received with `mp_en`=0.
- R12: While `sync_mode`=1 the asynchronous engines stay idle, `txd` stays high and no byte is taken from the transmit buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Standby request; reloads divisor, idles engines |
| div_we | input | 1 | Divisor write strobe |
| div_wdata | input | 8 | Divisor write value |
| div_rd | output | 8 | Divisor read-back |
| clk_sel | input | 2 | Prescaler select: 0=/1, 1=/4, 2=/16, 3=/64 |
| sync_mode | input | 1 | Synchronous mode selected; asynchronous engines held idle |
| mp_en | input | 1 | Multiprocessor flag-bit format enable |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| tx_mpb | input | 1 | Flag bit value for transmitted characters |
| tx_valid | input | 1 | Transmit stream valid |
| tx_data | input | 8 | Transmit stream byte |
| tx_ready | output | 1 | Transmit buffer empty / stream ready |
| rx_valid | output | 1 | Receive holding register full |
| rx_ready | input | 1 | Receive stream ready |
| rx_data | output | 8 | Received byte |
| rx_mpb | output | 1 | Last committed received flag bit (read-only status) |
| rx_ferr | output | 1 | Framing error status |
| txd | output | 1 | Serial transmit line, idle high |
| rxd | input | 1 | Serial receive line, asynchronous |

## Verification
The hardest situation to reach is the retention of `rx_mpb`, because that bit changes only through a correctly framed flag-format character. To show that it holds, the bench first commits a character whose flag is 1 and drains it. It then sends a character with flag 0 while the receiver is disabled, and later a plain 8-bit character. In both cases the old value must survive. Back-pressure loss needs the same care: a second character with a different flag is completed while the first one is still held, and both byte and flag must stay those of the first. Random loopback traffic over several divisor values then covers the transmit and receive sides together.

// File: rtl/mpser_pkg.sv
package mpser_pkg;

  typedef enum logic [2:0] {
    TS_IDLE,
    TS_START,
    TS_DATA,
    TS_FLAG,
    TS_STOP
  } tx_state_e;

  typedef enum logic [2:0] {
    RS_IDLE,
    RS_START,
    RS_DATA,
    RS_FLAG,
    RS_STOP,
    RS_WAITHI
  } rx_state_e;

endpackage

// File: rtl/mpser_baud.sv
module mpser_baud #(
  parameter int DIV_W        = 8,
  parameter int CS_W         = 2,
  parameter int PRE_STEP_LOG = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [CS_W-1:0]  clk_sel,
  input  logic [DIV_W-1:0] div,
  output logic             os_tick
);
  // Prescaler spans the largest step: (2^CS_W - 1) selects of PRE_STEP_LOG bits each
  localparam int PRE_W = PRE_STEP_LOG * ((1 << CS_W) - 1);

  logic [PRE_W-1:0] pcnt;
  logic [PRE_W-1:0] pmask;
  logic [DIV_W-1:0] dcnt;
  logic             pre_tick;

  // Low-order prescaler bits that must all be set for a prescaled tick
  for (genvar g = 0; g < PRE_W; g++) begin : g_mask
    assign pmask[g] = (g < PRE_STEP_LOG * int'(clk_sel));
  end

  assign pre_tick = ((pcnt & pmask) == pmask);
  assign os_tick  = pre_tick && (dcnt >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
      dcnt <= '0;
    end else if (clr) begin
      pcnt <= '0;
      dcnt <= '0;
    end else begin
      pcnt <= pcnt + 1'b1;
      if (pre_tick) begin
        if (os_tick) dcnt <= '0;
        else         dcnt <= dcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mpser_tx.sv
module mpser_tx
  import mpser_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OS_LOG = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              os_tick,
  input  logic              mp_en,
  input  logic              buf_full,
  input  logic [DATA_W-1:0] buf_data,
  input  logic              mpb_in,
  output logic              take,
  output logic              txd
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0]  LAST   = CNT_W'(DATA_W - 1);
  localparam logic [OS_LOG-1:0] OS_MAX = '1;

  tx_state_e         state;
  logic [OS_LOG-1:0] sub;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] shreg;
  logic              flag_q;
  logic              fmt_mp;
  logic              bit_end;

  assign take    = run && (state == TS_IDLE) && os_tick && buf_full;
  assign bit_end = os_tick && (sub == OS_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= TS_IDLE;
      sub    <= '0;
      cnt    <= '0;
      shreg  <= '0;
      flag_q <= 1'b0;
      fmt_mp <= 1'b0;
      txd    <= 1'b1;
    end else if (!run) begin
      state <= TS_IDLE;
      sub   <= '0;
      txd   <= 1'b1;
    end else begin
      if (state != TS_IDLE && os_tick) sub <= sub + 1'b1;
      case (state)
        TS_IDLE: begin
          if (take) begin
            shreg  <= buf_data;
            flag_q <= mpb_in;
            fmt_mp <= mp_en;
            txd    <= 1'b0;
            sub    <= '0;
            state  <= TS_START;
          end
        end
        TS_START: begin
          if (bit_end) begin
            txd   <= shreg[0];
            shreg <= shreg >> 1;
            cnt   <= '0;
            state <= TS_DATA;
          end
        end
        TS_DATA: begin
          if (bit_end) begin
            if (cnt == LAST) begin
              if (fmt_mp) begin
                txd   <= flag_q;
                state <= TS_FLAG;
              end else begin
                txd   <= 1'b1;
                state <= TS_STOP;
              end
            end else begin
              txd   <= shreg[0];
              shreg <= shreg >> 1;
              cnt   <= cnt + 1'b1;
            end
          end
        end
        TS_FLAG: begin
          if (bit_end) begin
            txd   <= 1'b1;
            state <= TS_STOP;
          end
        end
        TS_STOP: begin
          if (bit_end) state <= TS_IDLE;
        end
        default: state <= TS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mpser_rx.sv
module mpser_rx
  import mpser_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int OS_LOG      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              os_tick,
  input  logic              mp_en,
  input  logic              rxd,
  output logic              done,
  output logic              stop_ok,
  output logic              fmt_mp,
  output logic [DATA_W-1:0] word,
  output logic              flag
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0]  LAST    = CNT_W'(DATA_W - 1);
  localparam logic [OS_LOG-1:0] OS_MAX  = '1;
  localparam logic [OS_LOG-1:0] HALF_M1 = OS_LOG'((1 << OS_LOG) / 2 - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rx_s;
  rx_state_e              state;
  logic [OS_LOG-1:0]      sub;
  logic [CNT_W-1:0]       cnt;
  logic                   bit_end;

  assign rx_s    = sync_q[SYNC_STAGES-1];
  assign bit_end = os_tick && (sub == OS_MAX);
  assign done    = run && (state == RS_STOP) && bit_end;
  assign stop_ok = rx_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= RS_IDLE;
      sub    <= '0;
      cnt    <= '0;
      word   <= '0;
      flag   <= 1'b0;
      fmt_mp <= 1'b0;
    end else if (!run) begin
      state <= RS_IDLE;
      sub   <= '0;
    end else begin
      case (state)
        RS_IDLE: begin
          if (os_tick && !rx_s) begin
            sub    <= '0;
            fmt_mp <= mp_en;
            state  <= RS_START;
          end
        end
        RS_START: begin
          if (os_tick) begin
            if (sub == HALF_M1) begin
              sub <= '0;
              cnt <= '0;
              if (rx_s) state <= RS_IDLE;
              else      state <= RS_DATA;
            end else begin
              sub <= sub + 1'b1;
            end
          end
        end
        RS_DATA: begin
          if (os_tick) sub <= sub + 1'b1;
          if (bit_end) begin
            word <= {rx_s, word[DATA_W-1:1]};
            if (cnt == LAST) state <= fmt_mp ? RS_FLAG : RS_STOP;
            else             cnt   <= cnt + 1'b1;
          end
        end
        RS_FLAG: begin
          if (os_tick) sub <= sub + 1'b1;
          if (bit_end) begin
            flag  <= rx_s;
            state <= RS_STOP;
          end
        end
        RS_STOP: begin
          if (os_tick) sub <= sub + 1'b1;
          if (bit_end) state <= rx_s ? RS_IDLE : RS_WAITHI;
        end
        RS_WAITHI: begin
          if (rx_s) state <= RS_IDLE;
        end
        default: state <= RS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mpser_chan.sv
module mpser_chan #(
  parameter int DATA_W       = 8,
  parameter int DIV_W        = 8,
  parameter int CS_W         = 2,
  parameter int PRE_STEP_LOG = 2,
  parameter int OS_LOG       = 4,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              standby,
  input  logic              div_we,
  input  logic [DIV_W-1:0]  div_wdata,
  output logic [DIV_W-1:0]  div_rd,
  input  logic [CS_W-1:0]   clk_sel,
  input  logic              sync_mode,
  input  logic              mp_en,
  input  logic              tx_en,
  input  logic              rx_en,
  input  logic              tx_mpb,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_mpb,
  output logic              rx_ferr,
  output logic              txd,
  input  logic              rxd
);
  logic [DIV_W-1:0]  div_q;
  logic              os_tick;
  logic              tx_run;
  logic              rx_run;
  logic              take;
  logic              tx_full;
  logic [DATA_W-1:0] tx_buf;
  logic              rx_done;
  logic              rx_stop_ok;
  logic              rx_fmt_mp;
  logic [DATA_W-1:0] rx_word;
  logic              rx_flag;
  logic              rx_full;
  logic [DATA_W-1:0] rx_buf;
  logic              mpb_q;
  logic              ferr_q;

  assign tx_run = tx_en && !sync_mode && !standby;
  assign rx_run = rx_en && !sync_mode && !standby;

  // Divisor register: reloads all ones on reset and during standby
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       div_q <= '1;
    else if (standby) div_q <= '1;
    else if (div_we)  div_q <= div_wdata;
  end
  assign div_rd = div_q;

  mpser_baud #(
    .DIV_W(DIV_W), .CS_W(CS_W), .PRE_STEP_LOG(PRE_STEP_LOG)
  ) u_baud (
    .clk(clk), .rst_n(rst_n), .clr(standby),
    .clk_sel(clk_sel), .div(div_q), .os_tick(os_tick)
  );

  // Single-entry transmit buffer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_full <= 1'b0;
      tx_buf  <= '0;
    end else begin
      if (take) tx_full <= 1'b0;
      if (tx_valid && !tx_full) begin
        tx_full <= 1'b1;
        tx_buf  <= tx_data;
      end
    end
  end
  assign tx_ready = !tx_full;

  mpser_tx #(
    .DATA_W(DATA_W), .OS_LOG(OS_LOG)
  ) u_tx (
    .clk(clk), .rst_n(rst_n), .run(tx_run), .os_tick(os_tick),
    .mp_en(mp_en), .buf_full(tx_full), .buf_data(tx_buf),
    .mpb_in(tx_mpb), .take(take), .txd(txd)
  );

  mpser_rx #(
    .DATA_W(DATA_W), .OS_LOG(OS_LOG), .SYNC_STAGES(SYNC_STAGES)
  ) u_rx (
    .clk(clk), .rst_n(rst_n), .run(rx_run), .os_tick(os_tick),
    .mp_en(mp_en), .rxd(rxd), .done(rx_done), .stop_ok(rx_stop_ok),
    .fmt_mp(rx_fmt_mp), .word(rx_word), .flag(rx_flag)
  );

  // Receive holding register, flag status and framing status
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_full <= 1'b0;
      rx_buf  <= '0;
      mpb_q   <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      if (rx_full && rx_ready) rx_full <= 1'b0;
      if (rx_done) begin
        if (rx_stop_ok) begin
          ferr_q <= 1'b0;
          if (!rx_full) begin
            rx_full <= 1'b1;
            rx_buf  <= rx_word;
            if (rx_fmt_mp) mpb_q <= rx_flag;
          end
        end else begin
          ferr_q <= 1'b1;
        end
      end
    end
  end

  assign rx_valid = rx_full;
  assign rx_data  = rx_buf;
  assign rx_mpb   = mpb_q;
  assign rx_ferr  = ferr_q;
endmodule

// File: rtl/mpser_chan_chk.sv
module mpser_chan_chk #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              standby,
  input logic [DIV_W-1:0]  div_rd,
  input logic              sync_mode,
  input logic              rx_en,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [DATA_W-1:0] rx_data,
  input logic              rx_mpb,
  input logic              txd
);
  AST_DIV_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> (div_rd == '1)); // R2

  AST_LINE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> txd); // R2

  AST_TX_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready); // R6

  AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data) && $stable(rx_mpb))); // R10

  AST_MPB_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> $stable(rx_mpb)); // R11

  AST_SYNC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    sync_mode |=> txd); // R12
endmodule

bind mpser_chan mpser_chan_chk #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .standby(standby), .div_rd(div_rd),
  .sync_mode(sync_mode), .rx_en(rx_en), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .rx_data(rx_data), .rx_mpb(rx_mpb), .txd(txd)
);

// File: tb/mpser_chan_test.sv
module mpser_chan_test;
  logic       clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, standby, div_we, sync_mode, mp_en, tx_en, rx_en, tx_mpb;
  logic [7:0] div_wdata, div_rd, tx_data, rx_data;
  logic [1:0] clk_sel;
  logic       tx_valid, tx_ready, rx_valid, rx_ready, rx_mpb, rx_ferr, txd;
  logic       rxd_drv, loop_en, rxd_line;
  int         n_run = 0;
  int         n_fail = 0;
  int         bt = 32;
  bit         finished = 0;

  assign rxd_line = loop_en ? txd : rxd_drv;

  mpser_chan uut (
    .clk(clk), .rst_n(rst_n), .standby(standby), .div_we(div_we),
    .div_wdata(div_wdata), .div_rd(div_rd), .clk_sel(clk_sel),
    .sync_mode(sync_mode), .mp_en(mp_en), .tx_en(tx_en), .rx_en(rx_en),
    .tx_mpb(tx_mpb), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .rx_mpb(rx_mpb), .rx_ferr(rx_ferr), .txd(txd),
    .rxd(rxd_line)
  );

  function automatic int bit_len(int n, int sel);
    return 16 * (n + 1) * (1 << (2 * sel));
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic set_rate(input int n, input int sel);
    @(negedge clk);
    div_wdata = 8'(n);
    clk_sel   = 2'(sel);
    div_we    = 1'b1;
    @(negedge clk);
    div_we = 1'b0;
    bt = bit_len(n, sel);
  endtask

  task automatic push(input logic [7:0] d, input logic m);
    @(negedge clk);
    tx_mpb = m;
    while (!tx_ready) @(negedge clk);
    tx_valid = 1'b1;
    tx_data  = d;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_fall(output bit ok);
    int k = 0;
    while (txd && k < 20 * bt) begin
      @(negedge clk);
      k++;
    end
    ok = !txd;
  endtask

  // Samples mid-bit: data, then position 9 (flag or stop), then position 10
  task automatic cap_tx(output logic [7:0] d, output logic p9, output logic p10);
    bit ok;
    d = '0; p9 = 1'b0; p10 = 1'b0;
    wait_fall(ok);
    chk("R4", "start edge seen", 32'(ok), 32'd1);
    repeat (bt / 2) @(negedge clk);
    chk("R4", "start bit level", 32'(txd), 32'd0);
    for (int i = 0; i < 8; i++) begin
      repeat (bt) @(negedge clk);
      d[i] = txd;
    end
    repeat (bt) @(negedge clk);
    p9 = txd;
    repeat (bt) @(negedge clk);
    p10 = txd;
  endtask

  task automatic drive_rx(input logic [7:0] d, input logic m, input bit use_mp,
                          input logic stopv);
    @(negedge clk);
    rxd_drv = 1'b0;
    repeat (bt) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd_drv = d[i];
      repeat (bt) @(negedge clk);
    end
    if (use_mp) begin
      rxd_drv = m;
      repeat (bt) @(negedge clk);
    end
    rxd_drv = stopv;
    repeat (bt) @(negedge clk);
    rxd_drv = 1'b1;
    repeat (bt) @(negedge clk);
  endtask

  task automatic consume();
    @(negedge clk);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL R6 watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, exp_d;
    logic       p9, p10, m;
    bit         ok, low_seen;
    int         cnt;
    int         ns[4]   = '{2, 0, 1, 0};
    int         sels[4] = '{0, 1, 2, 3};
    void'($urandom(32'd7171));
    rst_n = 1'b0; standby = 1'b0; div_we = 1'b0; div_wdata = '0; clk_sel = '0;
    sync_mode = 1'b0; mp_en = 1'b1; tx_en = 1'b1; rx_en = 1'b1; tx_mpb = 1'b0;
    tx_valid = 1'b0; tx_data = '0; rx_ready = 1'b0; rxd_drv = 1'b1; loop_en = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1", "div_rd after reset", 32'(div_rd), 32'hFF);
    chk("R1", "tx_ready after reset", 32'(tx_ready), 32'd1);
    chk("R1", "rx_valid after reset", 32'(rx_valid), 32'd0);
    chk("R1", "txd after reset", 32'(txd), 32'd1);
    chk("R1", "rx_ferr after reset", 32'(rx_ferr), 32'd0);
    chk("R1", "rx_mpb after reset", 32'(rx_mpb), 32'd0);
    set_rate(8'h5A, 0);
    chk("R1", "div_rd write-back", 32'(div_rd), 32'h5A);

    // R3 bit period for each prescaler select
    for (int k = 0; k < 4; k++) begin
      set_rate(ns[k], sels[k]);
      push(8'h01, 1'b1);
      wait_fall(ok);
      cnt = 0;
      while (!txd && cnt < 4 * bt) begin
        @(negedge clk);
        cnt++;
      end
      chk("R3", $sformatf("start width sel=%0d", sels[k]), 32'(cnt), 32'(bit_len(ns[k], sels[k])));
      repeat (12 * bt) @(negedge clk);
    end

    // R4/R5 random flag-format frames
    set_rate(1, 0);
    for (int k = 0; k < 6; k++) begin
      exp_d = 8'($urandom);
      m = 1'($urandom);
      push(exp_d, m);
      cap_tx(d, p9, p10);
      chk("R4", "tx data", 32'(d), 32'(exp_d));
      chk("R5", "tx flag bit", 32'(p9), 32'(m));
      chk("R4", "tx stop bit", 32'(p10), 32'd1);
    end

    // R5 no flag bit when format off
    mp_en = 1'b0;
    push(8'hA5, 1'b0);
    cap_tx(d, p9, p10);
    chk("R5", "plain frame data", 32'(d), 32'hA5);
    chk("R5", "stop follows data bit 7", 32'(p9), 32'd1);
    chk("R5", "line idle after stop", 32'(p10), 32'd1);
    mp_en = 1'b1;

    // R12/R6 sync mode holds buffer, line quiet
    @(negedge clk);
    sync_mode = 1'b1;
    push(8'h3C, 1'b1);
    low_seen = 0;
    repeat (12 * bt) begin
      @(negedge clk);
      if (!txd) low_seen = 1;
    end
    chk("R12", "line low in sync mode", 32'(low_seen), 32'd0);
    chk("R6", "buffer kept, tx_ready", 32'(tx_ready), 32'd0);
    sync_mode = 1'b0;
    cap_tx(d, p9, p10);
    chk("R6", "held byte sent", 32'(d), 32'h3C);
    chk("R5", "held byte flag", 32'(p9), 32'd1);

    // R7 receive direct frames
    for (int k = 0; k < 5; k++) begin
      exp_d = 8'($urandom);
      m = 1'($urandom);
      drive_rx(exp_d, m, 1, 1'b1);
      chk("R7", "rx_valid", 32'(rx_valid), 32'd1);
      chk("R7", "rx_data", 32'(rx_data), 32'(exp_d));
      chk("R7", "rx_mpb", 32'(rx_mpb), 32'(m));
      consume();
      chk("R10", "rx_valid cleared", 32'(rx_valid), 32'd0);
    end

    // R8 false start
    @(negedge clk);
    rxd_drv = 1'b0;
    repeat (bt / 4) @(negedge clk);
    rxd_drv = 1'b1;
    repeat (12 * bt) @(negedge clk);
    chk("R8", "glitch not received", 32'(rx_valid), 32'd0);

    // R9 framing error, then recovery
    drive_rx(8'h55, 1'b1, 1, 1'b0);
    chk("R9", "ferr set", 32'(rx_ferr), 32'd1);
    chk("R9", "bad frame not committed", 32'(rx_valid), 32'd0);
    drive_rx(8'h66, 1'b0, 1, 1'b1);
    chk("R9", "ferr cleared", 32'(rx_ferr), 32'd0);
    chk("R9", "good frame data", 32'(rx_data), 32'h66);
    consume();

    // R10 back-pressure drops the second frame
    drive_rx(8'h11, 1'b1, 1, 1'b1);
    drive_rx(8'h22, 1'b0, 1, 1'b1);
    chk("R10", "first byte kept", 32'(rx_data), 32'h11);
    chk("R10", "first flag kept", 32'(rx_mpb), 32'd1);
    chk("R10", "still valid", 32'(rx_valid), 32'd1);
    consume();

    // R11 receiver off keeps flag
    rx_en = 1'b0;
    drive_rx(8'h33, 1'b0, 1, 1'b1);
    chk("R11", "no reception when off", 32'(rx_valid), 32'd0);
    chk("R11", "flag kept when off", 32'(rx_mpb), 32'd1);
    rx_en = 1'b1;
    mp_en = 1'b0;
    drive_rx(8'h44, 1'b0, 0, 1'b1);
    chk("R7", "plain frame received", 32'(rx_data), 32'h44);
    chk("R11", "flag kept on plain frame", 32'(rx_mpb), 32'd1);
    consume();
    mp_en = 1'b1;

    // R2 standby mid-frame
    push(8'h00, 1'b0);
    wait_fall(ok);
    repeat (3 * bt) @(negedge clk);
    standby = 1'b1;
    @(negedge clk);
    standby = 1'b0;
    chk("R2", "div reloaded", 32'(div_rd), 32'hFF);
    chk("R2", "line high", 32'(txd), 32'd1);
    repeat (4) @(negedge clk);
    chk("R2", "line stays high", 32'(txd), 32'd1);

    // R4/R7 random loopback
    loop_en = 1'b1;
    for (int k = 0; k < 12; k++) begin
      set_rate($urandom_range(0, 2), 0);
      exp_d = 8'($urandom);
      m = 1'($urandom);
      push(exp_d, m);
      cnt = 0;
      while (!rx_valid && cnt < 14 * bt) begin
        @(negedge clk);
        cnt++;
      end
      chk("R7", "loopback data", 32'(rx_data), 32'(exp_d));
      chk("R7", "loopback flag", 32'(rx_mpb), 32'(m));
      consume();
      repeat (2 * bt) @(negedge clk);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule